// File: doc/BRIEF.md
# Reduced Power and Emulation Mode Controller

This block decides, from one oscillator-rate clock, which operating mode a small microcontroller core is in: running, idle, power-down, the short oscillator warm-up that follows an interrupt wake from power-down, or on-circuit emulation. It qualifies the external reset pin, reacts to software requests for idle and power-down, brings the core back on interrupts, and drives the clock-enable and pin-override selects that each mode needs.

Reset is seen only after the reset pin has stayed high for a whole qualifying window. Idle stops the core clock and keeps peripheral clocks running. The counter-array clock follows a keep-running select. Power-down stops the oscillator. An enabled, level-sensitive external interrupt held low restarts it. The core clock returns once a programmable settle count has elapsed and the interrupt line has gone high again. A strap pattern on the address-latch and program-strobe sense inputs at the end of reset puts the block in emulation mode, where the pins are released for an external tester.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: `core_rst` rises only after `rst_pin` has been sampled high on RST_MC*CYC_PER_MC consecutive clocks (24 by default), so a shorter pulse leaves it low. It falls on the first clock edge that samples `rst_pin` low. While `core_rst` is high, `cpu_clk_en`, `periph_clk_en`, `pca_clk_en` and `osc_en` are 1 and `pin_drv` is 0.
- R2: In run mode all four enables are 1, and `pin_drv` is 0 (pins functional), `p0_float` is 0 and `port_weak` is 0.
- R3: A one-clock `idle_req` in run mode enters idle at the next edge. In idle, `cpu_clk_en`=0, `periph_clk_en`=1, `osc_en`=1, `pca_clk_en` equals `pca_idle_run`, `pin_drv`=1 (latch strobe and program strobe driven high), and `p0_float` equals `ext_code`.
- R4: Idle returns to run at the edge that samples `irq_pending` high, or when a qualified reset occurs.
- R5: A one-clock `pd_req` in run mode enters power-down at the next edge. There, `osc_en`, `cpu_clk_en`, `periph_clk_en` and `pca_clk_en` are 0, `pin_drv`=2 (strobes driven low) and `p0_float` equals `ext_code`. When `pd_req` and `idle_req` are both high, power-down wins.
- R6: In power-down, the edge that samples some line i with `ext_int_n[i]`=0, `ext_int_en[i]`=1 and `ext_int_lvl[i]`=1 sets `osc_en` to 1 while `cpu_clk_en` stays 0. A low line that lacks either enable or level mode, or a high `irq_pending`, leaves `osc_en` at 0.
- R7: After a wake starts at edge E, run mode (all enables 1, `pin_drv`=0) returns at the first edge after E+`stable_cnt` that samples every qualified wake line high. It never returns earlier, even when the line is released at once.
- R8: A qualified reset during power-down or warm-up takes priority over an interrupt wake. After `rst_pin` falls, the block is in run mode at once, with no settle count, even if the wake line is still low.
- R9: Emulation mode is entered at the edge where `core_rst` falls if, while `core_rst` was high, `ale_sense` was seen 0 with `psen_sense` 1, and `ale_sense` is still 0 at that edge. Then `emu_mode`=1, `pin_drv`=3 (weak high), `p0_float`=1, `port_weak`=1, `osc_en`=1, and `cpu_clk_en`, `periph_clk_en` and `pca_clk_en` are 0. `idle_req` and `pd_req` have no effect in this mode.
- R10: A qualified reset clears `emu_mode` (it is 0 whenever `core_rst` is 1). A reset released with `ale_sense` high leaves the block in run mode.
- R11: When the strap was seen but `ale_sense` is 1 at the release edge, or when `psen_sense` was 0 throughout reset, emulation is not entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| arst_n | input | 1 | Asynchronous power-on clear, active low |
| rst_pin | input | 1 | Raw external reset pin, active high |
| ale_sense | input | 1 | Sensed level of the address-latch strobe pin |
| psen_sense | input | 1 | Sensed level of the program-store strobe pin |
| idle_req | input | 1 | Software idle request, one clock |
| pd_req | input | 1 | Software power-down request, one clock |
| irq_pending | input | 1 | Any enabled interrupt is pending |
| ext_int_n | input | N_EXT | External interrupt pin levels, active low |
| ext_int_en | input | N_EXT | Per-line interrupt enable |
| ext_int_lvl | input | N_EXT | Per-line level-sensitive select (1 = level) |
| pca_idle_run | input | 1 | Keep the counter-array clock running in idle |
| ext_code | input | 1 | Core executes from external program memory |
| stable_cnt | input | STABLE_W | Oscillator settle count for power-down wake |
| cpu_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| pca_clk_en | output | 1 | Counter-array clock enable |
| osc_en | output | 1 | Oscillator enable |
| core_rst | output | 1 | Qualified internal reset |
| pin_drv | output | 2 | Strobe pin override: 0 functional, 1 high, 2 low, 3 weak high |
| p0_float | output | 1 | Float the multiplexed address/data port |
| port_weak | output | 1 | Weak pull-up on the other ports |
| emu_mode | output | 1 | Emulation mode flag |

## Verification
Every cycle, the assertions check that a rising reset was preceded by the full window of high samples and that a low reset pin clears it at the next edge. They also check that a stopped oscillator always comes with stopped clocks and low strobes, that idle always drives the strobes high, and that emulation and reset are never active together. Only the bench scenarios can show the mode sequences: the exact edge at which idle, power-down and warm-up are entered and left, and that unqualified or software interrupts cannot wake power-down. They also show that reset overrides a pending wake, and how the strap pattern, its abort and its clearing by a later reset each decide whether emulation is entered.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
   typedef enum logic [1:0] {
      M_RUN  = 2'd0,
      M_IDLE = 2'd1,
      M_PD   = 2'd2,
      M_WARM = 2'd3
   } pmc_mode_e;

   typedef enum logic [1:0] {
      PIN_FUNC = 2'd0,
      PIN_HIGH = 2'd1,
      PIN_LOW  = 2'd2,
      PIN_WEAK = 2'd3
   } pin_drv_e;
endpackage

// File: rtl/pmc_rst_filt.sv
module pmc_rst_filt #(
   parameter int RST_CLKS = 24,
   parameter bit EMU_EN   = 1'b1
) (
   input  logic clk,
   input  logic arst_n,
   input  logic rst_pin,
   input  logic ale_sense,
   input  logic psen_sense,
   output logic core_rst,
   output logic emu_mode
);
   localparam int CW = $clog2(RST_CLKS + 1);
   localparam logic [CW-1:0] HI_MAX = CW'(RST_CLKS);
   localparam logic [CW-1:0] HI_TRIP = CW'(RST_CLKS - 1);

   logic [CW-1:0] hcnt;
   logic          rst_q;
   logic          rst_d;

   // next reset state: sticky while the pin stays high
   assign rst_d = rst_pin && (rst_q || (hcnt >= HI_TRIP));

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         hcnt  <= '0;
         rst_q <= 1'b0;
      end else begin
         rst_q <= rst_d;
         if (!rst_pin)
            hcnt <= '0;
         else if (hcnt != HI_MAX)
            hcnt <= hcnt + 1'b1;
      end
   end

   assign core_rst = rst_q;

   generate
      if (EMU_EN) begin : g_emu
         logic arm_q;
         logic arm_d;
         logic emu_q;

         assign arm_d = arm_q || (!ale_sense && psen_sense);

         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) begin
               arm_q <= 1'b0;
               emu_q <= 1'b0;
            end else begin
               arm_q <= rst_q ? arm_d : 1'b0;
               if (rst_d)
                  emu_q <= 1'b0;
               else if (rst_q)
                  emu_q <= arm_d && !ale_sense;
            end
         end
         assign emu_mode = emu_q;
      end else begin : g_no_emu
         logic unused_straps;
         assign unused_straps = ale_sense ^ psen_sense;
         assign emu_mode = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
   import pmc_pkg::*;
#(
   parameter int STABLE_W = 16
) (
   input  logic                clk,
   input  logic                arst_n,
   input  logic                core_rst,
   input  logic                emu_mode,
   input  logic                idle_req,
   input  logic                pd_req,
   input  logic                irq_pending,
   input  logic                wake_low,
   input  logic [STABLE_W-1:0] stable_cnt,
   output pmc_mode_e           mode
);
   pmc_mode_e           mode_q;
   logic [STABLE_W-1:0] settle_q;
   logic                settled;

   assign settled = (settle_q >= stable_cnt);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         mode_q   <= M_RUN;
         settle_q <= '0;
      end else if (core_rst) begin
         mode_q   <= M_RUN;
         settle_q <= '0;
      end else begin
         unique case (mode_q)
            M_RUN: begin
               if (!emu_mode) begin
                  if (pd_req)        mode_q <= M_PD;
                  else if (idle_req) mode_q <= M_IDLE;
               end
            end
            M_IDLE: begin
               if (irq_pending) mode_q <= M_RUN;
            end
            M_PD: begin
               if (wake_low) begin
                  mode_q   <= M_WARM;
                  settle_q <= '0;
               end
            end
            M_WARM: begin
               if (!settled)
                  settle_q <= settle_q + 1'b1;
               else if (!wake_low)
                  mode_q <= M_RUN;
            end
            default: mode_q <= M_RUN;
         endcase
      end
   end

   assign mode = mode_q;
endmodule

// File: rtl/pmc_out_dec.sv
module pmc_out_dec
   import pmc_pkg::*;
(
   input  pmc_mode_e  mode,
   input  logic       core_rst,
   input  logic       emu_mode,
   input  logic       pca_idle_run,
   input  logic       ext_code,
   output logic       cpu_clk_en,
   output logic       periph_clk_en,
   output logic       pca_clk_en,
   output logic       osc_en,
   output logic [1:0] pin_drv,
   output logic       p0_float,
   output logic       port_weak
);
   pin_drv_e drv;

   always_comb begin
      cpu_clk_en    = 1'b1;
      periph_clk_en = 1'b1;
      pca_clk_en    = 1'b1;
      osc_en        = 1'b1;
      drv           = PIN_FUNC;
      p0_float      = 1'b0;
      port_weak     = 1'b0;
      if (core_rst) begin
         drv = PIN_FUNC;
      end else if (emu_mode) begin
         cpu_clk_en    = 1'b0;
         periph_clk_en = 1'b0;
         pca_clk_en    = 1'b0;
         drv           = PIN_WEAK;
         p0_float      = 1'b1;
         port_weak     = 1'b1;
      end else begin
         unique case (mode)
            M_IDLE: begin
               cpu_clk_en = 1'b0;
               pca_clk_en = pca_idle_run;
               drv        = PIN_HIGH;
               p0_float   = ext_code;
            end
            M_PD, M_WARM: begin
               cpu_clk_en    = 1'b0;
               periph_clk_en = 1'b0;
               pca_clk_en    = 1'b0;
               osc_en        = (mode == M_WARM);
               drv           = PIN_LOW;
               p0_float      = ext_code;
            end
            default: drv = PIN_FUNC;
         endcase
      end
   end

   assign pin_drv = drv;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pmc_pkg::*;
#(
   parameter int CYC_PER_MC = 12,
   parameter int RST_MC     = 2,
   parameter int N_EXT      = 2,
   parameter int STABLE_W   = 16,
   parameter bit EMU_EN     = 1'b1
) (
   input  logic                clk,
   input  logic                arst_n,
   input  logic                rst_pin,
   input  logic                ale_sense,
   input  logic                psen_sense,
   input  logic                idle_req,
   input  logic                pd_req,
   input  logic                irq_pending,
   input  logic [N_EXT-1:0]    ext_int_n,
   input  logic [N_EXT-1:0]    ext_int_en,
   input  logic [N_EXT-1:0]    ext_int_lvl,
   input  logic                pca_idle_run,
   input  logic                ext_code,
   input  logic [STABLE_W-1:0] stable_cnt,
   output logic                cpu_clk_en,
   output logic                periph_clk_en,
   output logic                pca_clk_en,
   output logic                osc_en,
   output logic                core_rst,
   output logic [1:0]          pin_drv,
   output logic                p0_float,
   output logic                port_weak,
   output logic                emu_mode
);
   localparam int RST_CLKS = CYC_PER_MC * RST_MC;

   generate
      if (CYC_PER_MC < 1) begin : g_bad_mc
         $error("CYC_PER_MC must be at least 1");
      end
      if (RST_MC < 1) begin : g_bad_rst
         $error("RST_MC must be at least 1");
      end
      if (N_EXT < 1) begin : g_bad_ext
         $error("N_EXT must be at least 1");
      end
      if (STABLE_W < 1) begin : g_bad_w
         $error("STABLE_W must be at least 1");
      end
   endgenerate

   logic [N_EXT-1:0] wake_vec;
   logic             wake_low;
   pmc_mode_e        mode;

   generate
      for (genvar i = 0; i < N_EXT; i++) begin : g_wake
         assign wake_vec[i] = !ext_int_n[i] && ext_int_en[i] && ext_int_lvl[i];
      end
   endgenerate
   assign wake_low = |wake_vec;

   pmc_rst_filt #(.RST_CLKS(RST_CLKS), .EMU_EN(EMU_EN)) u_filt (
      .clk        (clk),
      .arst_n     (arst_n),
      .rst_pin    (rst_pin),
      .ale_sense  (ale_sense),
      .psen_sense (psen_sense),
      .core_rst   (core_rst),
      .emu_mode   (emu_mode)
   );

   pmc_mode_fsm #(.STABLE_W(STABLE_W)) u_fsm (
      .clk         (clk),
      .arst_n      (arst_n),
      .core_rst    (core_rst),
      .emu_mode    (emu_mode),
      .idle_req    (idle_req),
      .pd_req      (pd_req),
      .irq_pending (irq_pending),
      .wake_low    (wake_low),
      .stable_cnt  (stable_cnt),
      .mode        (mode)
   );

   pmc_out_dec u_dec (
      .mode          (mode),
      .core_rst      (core_rst),
      .emu_mode      (emu_mode),
      .pca_idle_run  (pca_idle_run),
      .ext_code      (ext_code),
      .cpu_clk_en    (cpu_clk_en),
      .periph_clk_en (periph_clk_en),
      .pca_clk_en    (pca_clk_en),
      .osc_en        (osc_en),
      .pin_drv       (pin_drv),
      .p0_float      (p0_float),
      .port_weak     (port_weak)
   );
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk #(
   parameter int CYC_PER_MC = 12,
   parameter int RST_MC     = 2
) (
   input logic       clk,
   input logic       arst_n,
   input logic       rst_pin,
   input logic       core_rst,
   input logic       cpu_clk_en,
   input logic       periph_clk_en,
   input logic       osc_en,
   input logic [1:0] pin_drv,
   input logic       p0_float,
   input logic       port_weak,
   input logic       emu_mode
);
   localparam int RST_CLKS = CYC_PER_MC * RST_MC;
   localparam int HW = $clog2(RST_CLKS + 1);
   localparam logic [HW-1:0] H_MAX = HW'(RST_CLKS);

   logic [HW-1:0] high_run;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)
         high_run <= '0;
      else if (!rst_pin)
         high_run <= '0;
      else if (high_run != H_MAX)
         high_run <= high_run + 1'b1;
   end

   // R1: a reset is never seen before the full qualifying window
   a_r1_full_window: assert property (@(posedge clk) disable iff (!arst_n)
      $rose(core_rst) |-> (high_run == H_MAX));

   // R1: a low pin releases the reset at the next edge
   a_r1_release: assert property (@(posedge clk) disable iff (!arst_n)
      !rst_pin |=> !core_rst);

   // R1: clocks and oscillator run during reset
   a_r1_rst_clocks: assert property (@(posedge clk) disable iff (!arst_n)
      core_rst |-> (cpu_clk_en && periph_clk_en && osc_en));

   // R5: a stopped oscillator means stopped clocks and low strobes
   a_r5_osc_off: assert property (@(posedge clk) disable iff (!arst_n)
      !osc_en |-> (!cpu_clk_en && !periph_clk_en && pin_drv == 2'd2));

   // R3: idle drives the strobes high
   a_r3_idle_pins: assert property (@(posedge clk) disable iff (!arst_n)
      (!core_rst && !emu_mode && !cpu_clk_en && periph_clk_en) |-> (pin_drv == 2'd1));

   // R9: emulation releases the pins
   a_r9_emu_pins: assert property (@(posedge clk) disable iff (!arst_n)
      emu_mode |-> (p0_float && port_weak && pin_drv == 2'd3 && osc_en && !cpu_clk_en));

   // R10: emulation and reset never overlap
   a_r10_no_emu_in_rst: assert property (@(posedge clk) disable iff (!arst_n)
      core_rst |-> !emu_mode);
endmodule

bind pwr_mode_ctrl pmc_chk #(.CYC_PER_MC(CYC_PER_MC), .RST_MC(RST_MC)) u_chk (
   .clk           (clk),
   .arst_n        (arst_n),
   .rst_pin       (rst_pin),
   .core_rst      (core_rst),
   .cpu_clk_en    (cpu_clk_en),
   .periph_clk_en (periph_clk_en),
   .osc_en        (osc_en),
   .pin_drv       (pin_drv),
   .p0_float      (p0_float),
   .port_weak     (port_weak),
   .emu_mode      (emu_mode)
);

// File: tb/tb_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_mode_ctrl;
   localparam int RW = 24;

   logic        clk = 1'b0;
   logic        arst_n, rst_pin, ale_sense, psen_sense;
   logic        idle_req, pd_req, irq_pending;
   logic [1:0]  ext_int_n, ext_int_en, ext_int_lvl;
   logic        pca_idle_run, ext_code;
   logic [15:0] stable_cnt;
   logic        cpu_clk_en, periph_clk_en, pca_clk_en, osc_en, core_rst;
   logic [1:0]  pin_drv;
   logic        p0_float, port_weak, emu_mode;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pwr_mode_ctrl dut (
      .clk(clk), .arst_n(arst_n), .rst_pin(rst_pin), .ale_sense(ale_sense),
      .psen_sense(psen_sense), .idle_req(idle_req), .pd_req(pd_req),
      .irq_pending(irq_pending), .ext_int_n(ext_int_n), .ext_int_en(ext_int_en),
      .ext_int_lvl(ext_int_lvl), .pca_idle_run(pca_idle_run), .ext_code(ext_code),
      .stable_cnt(stable_cnt), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
      .pca_clk_en(pca_clk_en), .osc_en(osc_en), .core_rst(core_rst), .pin_drv(pin_drv),
      .p0_float(p0_float), .port_weak(port_weak), .emu_mode(emu_mode)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // packs {cpu,periph,pca,osc,pin_drv,p0_float,port_weak,emu}
   function automatic int outs();
      return {cpu_clk_en, periph_clk_en, pca_clk_en, osc_en, pin_drv, p0_float, port_weak, emu_mode};
   endfunction

   function automatic int pack(input bit c, input bit p, input bit a, input bit o,
                               input int d, input bit f, input bit w, input bit e);
      return {c, p, a, o, d[1:0], f, w, e};
   endfunction

   task automatic do_reset(input int hi);
      rst_pin = 1'b1;
      tick(hi);
      rst_pin = 1'b0;
      tick(1);
   endtask

   task automatic t_reset_state;
      chk("R2 run after power-on", outs(), pack(1,1,1,1,0,0,0,0));
      chk("R1 no reset after power-on", core_rst, 0);
   endtask

   task automatic t_rst_filter;
      rst_pin = 1'b1;
      tick(RW - 1);
      chk("R1 short pulse no reset", core_rst, 0);
      rst_pin = 1'b0;
      tick(1);
      chk("R1 short pulse after drop", core_rst, 0);
      rst_pin = 1'b1;
      tick(RW - 1);
      chk("R1 one sample short", core_rst, 0);
      tick(1);
      chk("R1 full window", core_rst, 1);
      chk("R1 clocks during reset", outs(), pack(1,1,1,1,0,0,0,0));
      rst_pin = 1'b0;
      tick(1);
      chk("R1 release edge", core_rst, 0);
      chk("R2 run after reset", outs(), pack(1,1,1,1,0,0,0,0));
   endtask

   task automatic t_idle;
      pca_idle_run = 1'b0;
      ext_code = 1'b1;
      idle_req = 1'b1;
      tick(1);
      idle_req = 1'b0;
      chk("R3 idle entry", outs(), pack(0,1,0,1,1,1,0,0));
      tick(3);
      chk("R3 idle held", outs(), pack(0,1,0,1,1,1,0,0));
      pca_idle_run = 1'b1;
      tick(1);
      chk("R3 counter array runs in idle", pca_clk_en, 1);
      irq_pending = 1'b1;
      tick(1);
      irq_pending = 1'b0;
      chk("R4 idle exit by interrupt", outs(), pack(1,1,1,1,0,0,0,0));
      idle_req = 1'b1;
      tick(1);
      idle_req = 1'b0;
      chk("R3 idle re-entry", cpu_clk_en, 0);
      do_reset(RW + 2);
      chk("R4 idle exit by reset", outs(), pack(1,1,1,1,0,0,0,0));
   endtask

   task automatic t_pd_wake;
      ext_code = 1'b0;
      stable_cnt = 16'd5;
      pd_req = 1'b1;
      idle_req = 1'b1;
      tick(1);
      pd_req = 1'b0;
      idle_req = 1'b0;
      chk("R5 power-down wins over idle", outs(), pack(0,0,0,0,2,0,0,0));
      irq_pending = 1'b1;
      tick(3);
      irq_pending = 1'b0;
      chk("R6 pending irq does not wake", osc_en, 0);
      ext_int_en = 2'b11;
      ext_int_lvl = 2'b10;
      ext_int_n = 2'b10;
      tick(3);
      chk("R6 edge-mode line does not wake", osc_en, 0);
      ext_int_en = 2'b01;
      ext_int_lvl = 2'b11;
      ext_int_n = 2'b01;
      tick(3);
      chk("R6 disabled line does not wake", osc_en, 0);
      ext_int_n = 2'b10;
      tick(1);
      chk("R6 wake restarts oscillator", outs(), pack(0,0,0,1,2,0,0,0));
      tick(20);
      chk("R7 held low keeps core stopped", cpu_clk_en, 0);
      ext_int_n = 2'b11;
      tick(1);
      chk("R7 exit after release", outs(), pack(1,1,1,1,0,0,0,0));
   endtask

   task automatic t_early_release;
      stable_cnt = 16'd20;
      pd_req = 1'b1;
      tick(1);
      pd_req = 1'b0;
      ext_int_n = 2'b10;
      tick(1);
      ext_int_n = 2'b11;
      chk("R6 wake entry", osc_en, 1);
      tick(19);
      chk("R7 settle count not elapsed", cpu_clk_en, 0);
      tick(3);
      chk("R7 run after settle count", outs(), pack(1,1,1,1,0,0,0,0));
   endtask

   task automatic t_rst_priority;
      stable_cnt = 16'd1000;
      pd_req = 1'b1;
      tick(1);
      pd_req = 1'b0;
      chk("R5 power-down entry", osc_en, 0);
      ext_int_n = 2'b10;
      rst_pin = 1'b1;
      tick(RW + 1);
      chk("R8 reset during wake", core_rst, 1);
      rst_pin = 1'b0;
      tick(1);
      chk("R8 run without settle count", outs(), pack(1,1,1,1,0,0,0,0));
      ext_int_n = 2'b11;
   endtask

   task automatic t_emu;
      ale_sense = 1'b0;
      psen_sense = 1'b1;
      rst_pin = 1'b1;
      tick(RW + 6);
      chk("R10 no emulation during reset", emu_mode, 0);
      rst_pin = 1'b0;
      tick(1);
      chk("R9 emulation entry", outs(), pack(0,0,0,1,3,1,1,1));
      ale_sense = 1'b1;
      pd_req = 1'b1;
      idle_req = 1'b1;
      tick(2);
      pd_req = 1'b0;
      idle_req = 1'b0;
      chk("R9 requests ignored in emulation", outs(), pack(0,0,0,1,3,1,1,1));
      do_reset(RW + 1);
      chk("R10 normal reset leaves emulation", outs(), pack(1,1,1,1,0,0,0,0));
   endtask

   task automatic t_emu_abort;
      ale_sense = 1'b0;
      psen_sense = 1'b1;
      rst_pin = 1'b1;
      tick(RW + 6);
      ale_sense = 1'b1;
      tick(1);
      rst_pin = 1'b0;
      tick(1);
      chk("R11 latch strobe high at release", emu_mode, 0);
      ale_sense = 1'b0;
      psen_sense = 1'b0;
      do_reset(RW + 4);
      chk("R11 program strobe low blocks entry", emu_mode, 0);
      chk("R11 run after blocked entry", cpu_clk_en, 1);
      ale_sense = 1'b1;
      psen_sense = 1'b1;
   endtask

   initial begin
      arst_n = 1'b0; rst_pin = 1'b0; ale_sense = 1'b1; psen_sense = 1'b1;
      idle_req = 1'b0; pd_req = 1'b0; irq_pending = 1'b0;
      ext_int_n = 2'b11; ext_int_en = 2'b00; ext_int_lvl = 2'b00;
      pca_idle_run = 1'b0; ext_code = 1'b0; stable_cnt = 16'd5;
      tick(3);
      arst_n = 1'b1;
      tick(1);
      t_reset_state();
      t_rst_filter();
      t_idle();
      t_pd_wake();
      t_early_release();
      t_rst_priority();
      t_emu();
      t_emu_abort();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule